// File: doc/BRIEF.md
# Two-Slot Elastic Buffer

This block takes the place of an ordinary pipeline register on a synchronous channel that uses a valid/stop handshake. A cycle on a channel is a transfer when valid is high and stop is low, a retry when both are high, and idle when valid is low. The buffer can hold up to two items. The item at the head of the buffer sits in a main register that drives the output directly. A second, auxiliary register takes the item that arrives while the output is blocked.

A three-state controller drives the load enables of both registers. The state register is the pair of handshake outputs (`valid_out`, `stop_out`), so back-pressure toward the sender comes straight from a flip-flop. The buffer raises stop one cycle after it was blocked and filled, never in the same cycle. Because the second slot absorbs the item that is in flight during that cycle, nothing is lost. The data width and the value the data registers take at reset are parameters.

The states are EMPTY (no item), HALF (one item) and FULL (two items). The transitions are:
- FILL: EMPTY to HALF.
- PASS: HALF to HALF, with a new item replacing the departing one.
- STALL: HALF to FULL.
- DRAIN: HALF to EMPTY.
- RELEASE: FULL to HALF.
- A hold that keeps the current state in every other case.

Top module: `elastic_pair_buffer`

## Requirements
- R1: While `rst_n` is low, `valid_out` and `stop_out` are 0 and `data_out` equals the `DATA_RST` parameter.
- R2: The state is encoded as (`valid_out`, `stop_out`): EMPTY = (0,0), HALF = (1,0), FULL = (1,1). The code (0,1) never appears. Both outputs come from registers, so they do not change in response to inputs within a cycle.
- R3: FILL: in EMPTY with `valid_in` high, the next cycle is HALF and `data_out` holds the item taken in.
- R4: PASS: in HALF with `valid_in` high and `stop_in` low, the buffer stays in HALF. In the next cycle `data_out` is the new item.
- R5: STALL: in HALF with `valid_in` and `stop_in` both high, the next cycle is FULL (`stop_out` = 1). `data_out` keeps the older item and the new item goes into the auxiliary register.
- R6: DRAIN: in HALF with `valid_in` low and `stop_in` low, the next cycle is EMPTY.
- R7: During an output retry (`valid_out` and `stop_in` high), the next cycle still has `valid_out` high with `data_out` unchanged.
- R8: RELEASE: in FULL with `stop_in` low, the next cycle is HALF, `stop_out` is low, and `data_out` is the item that was in the auxiliary register.
- R9: In FULL, `valid_in` and `data_in` are ignored. No item is taken in, and FULL is kept while `stop_in` stays high.
- R10: Items leave in the order they were accepted. Under any valid/stop pattern, none is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Sender offers an item |
| stop_out | output | 1 | Back-pressure to the sender (buffer full) |
| data_in | input | DATA_W | Item from the sender |
| valid_out | output | 1 | Buffer offers its head item |
| stop_in | input | 1 | Back-pressure from the receiver |
| data_out | output | DATA_W | Head item |

## Verification
On every cycle, the assertions check the state encoding and each named transition (FILL, PASS, STALL, DRAIN, RELEASE and the FULL hold). They also check that the output persists through a retry, that the auxiliary register is never loaded in FULL, and that RELEASE moves the auxiliary item to the output. Only the bench scenarios can show end-to-end ordering: a queue model fed with the accepted items proves that every item arrives exactly once and in order. The same scenarios show that data offered while the buffer is full is not picked up and that the reset value appears on the data output.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;

    // State code is the handshake output pair {valid_out, stop_out}
    typedef enum logic [1:0] {
        ST_EMPTY = 2'b00,
        ST_HALF  = 2'b10,
        ST_FULL  = 2'b11
    } ebuf_state_e;

    // Storage slots: index 0 drives the output, index 1 is the overflow slot
    localparam int NSLOT     = 2;
    localparam int SLOT_MAIN = 0;
    localparam int SLOT_AUX  = 1;

endpackage

// File: rtl/ebuf_dreg.sv
module ebuf_dreg #(
    parameter int           W   = 16,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/ebuf_ctrl.sv
module ebuf_ctrl
    import ebuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic valid_in,
    input  logic stop_in,
    output logic valid_out,
    output logic stop_out,
    output logic main_en,
    output logic aux_en,
    output logic main_from_aux
);

    ebuf_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and register enables
    always_comb begin
        state_d       = state_q;
        main_en       = 1'b0;
        aux_en        = 1'b0;
        main_from_aux = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (valid_in) begin            // FILL
                    state_d = ST_HALF;
                    main_en = 1'b1;
                end
            end
            ST_HALF: begin
                unique case ({valid_in, stop_in})
                    2'b10: begin               // PASS
                        main_en = 1'b1;
                    end
                    2'b11: begin               // STALL
                        state_d = ST_FULL;
                        aux_en  = 1'b1;
                    end
                    2'b00: begin               // DRAIN
                        state_d = ST_EMPTY;
                    end
                    default: begin             // hold on retry
                        state_d = ST_HALF;
                    end
                endcase
            end
            ST_FULL: begin
                if (!stop_in) begin            // RELEASE
                    state_d       = ST_HALF;
                    main_en       = 1'b1;
                    main_from_aux = 1'b1;
                end
            end
            default: begin
                state_d = ST_EMPTY;
            end
        endcase
    end

    // Outputs: the handshake pair is the state code
    always_comb begin
        {valid_out, stop_out} = state_q;
    end

    assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_out |-> valid_out);

    assert_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_out && valid_in) |=> (valid_out && !stop_out));

    assert_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && !stop_out && valid_in && !stop_in) |=> (valid_out && !stop_out));

    assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && !stop_out && valid_in && stop_in) |=> stop_out);

    assert_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && !stop_out && !valid_in && !stop_in) |=> !valid_out);

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_out && !stop_in) |=> (valid_out && !stop_out));

    assert_full_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_out && stop_in) |=> stop_out);

    assert_full_no_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_out |-> !aux_en);

endmodule

// File: rtl/elastic_pair_buffer.sv
module elastic_pair_buffer
    import ebuf_pkg::*;
#(
    parameter int                DATA_W   = 16,
    parameter logic [DATA_W-1:0] DATA_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    output logic              stop_out,
    input  logic [DATA_W-1:0] data_in,
    output logic              valid_out,
    input  logic              stop_in,
    output logic [DATA_W-1:0] data_out
);

    logic              main_en;
    logic              aux_en;
    logic              main_from_aux;
    logic              slot_en [NSLOT];
    logic [DATA_W-1:0] slot_d  [NSLOT];
    logic [DATA_W-1:0] slot_q  [NSLOT];

    ebuf_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .valid_in      (valid_in),
        .stop_in       (stop_in),
        .valid_out     (valid_out),
        .stop_out      (stop_out),
        .main_en       (main_en),
        .aux_en        (aux_en),
        .main_from_aux (main_from_aux)
    );

    // Steering into the two storage slots
    always_comb begin
        slot_en[SLOT_MAIN] = main_en;
        slot_en[SLOT_AUX]  = aux_en;
        slot_d[SLOT_MAIN]  = main_from_aux ? slot_q[SLOT_AUX] : data_in;
        slot_d[SLOT_AUX]   = data_in;
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        ebuf_dreg #(
            .W   (DATA_W),
            .RST (DATA_RST)
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (slot_en[g]),
            .d     (slot_d[g]),
            .q     (slot_q[g])
        );
    end

    assign data_out = slot_q[SLOT_MAIN];

    assert_retry_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && stop_in) |=> (valid_out && $stable(data_out)));

    assert_release_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_out && !stop_in) |=> (data_out == $past(slot_q[SLOT_AUX])));

    assert_stall_keeps_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && !stop_out && valid_in && stop_in) |=> $stable(data_out));

endmodule

// File: tb/elastic_pair_buffer_tb.sv
`timescale 1ns/1ps
module elastic_pair_buffer_tb;

    localparam int          W    = 16;
    localparam logic [W-1:0] RSTV = 16'hA5C3;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_v  = 1'b0;
    logic         in_s  = 1'b0;
    logic [W-1:0] in_d  = '0;
    logic         out_v;
    logic         out_s;
    logic [W-1:0] out_d;

    always #2.5 clk = ~clk;

    elastic_pair_buffer #(.DATA_W(W), .DATA_RST(RSTV)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (in_v),
        .stop_out  (out_s),
        .data_in   (in_d),
        .valid_out (out_v),
        .stop_in   (in_s),
        .data_out  (out_d)
    );

    int           n_cmp = 0;
    int           n_bad = 0;
    bit           done  = 1'b0;
    logic [W-1:0] ref_q[$];

    task automatic chk(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare outputs with the queue model: occupancy gives the handshake pair
    task automatic cmp_all(input string tag);
        chk(tag, "valid_out", W'(out_v), W'(ref_q.size() != 0));
        chk(tag, "stop_out",  W'(out_s), W'(ref_q.size() == 2));
        if (ref_q.size() != 0) chk(tag, "data_out", out_d, ref_q[0]);
    endtask

    task automatic step(input logic v, input logic [W-1:0] d, input logic s,
                        input string tag, output bit accepted);
        bit dlv;
        @(negedge clk);
        in_v = v; in_d = d; in_s = s;
        accepted = v && (ref_q.size() < 2);
        dlv      = (ref_q.size() > 0) && !s;
        if (dlv) void'(ref_q.pop_front());
        if (accepted) ref_q.push_back(d);
        @(posedge clk);
        #1;
        cmp_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R10 watchdog actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit           acc;
        bit           pending;
        logic [W-1:0] item;
        int           vprob[4];
        int           sprob[4];
        vprob = '{90, 50, 30, 70};
        sprob = '{10, 50, 80, 30};

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "valid_out", W'(out_v), '0);
        chk("R1", "stop_out",  W'(out_s), '0);
        chk("R1", "data_out",  out_d, RSTV);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed walk through every transition
        step(1'b1, 16'h0A01, 1'b0, "R3", acc);   // FILL
        step(1'b1, 16'h0B02, 1'b0, "R4", acc);   // PASS
        step(1'b1, 16'h0C03, 1'b1, "R5", acc);   // STALL -> FULL, head kept
        step(1'b1, 16'h0D04, 1'b1, "R9", acc);   // FULL, input ignored
        step(1'b1, 16'h0E05, 1'b1, "R7", acc);   // retry persists
        chk("R2", "stop_implies_valid", W'(out_s && !out_v), '0);
        step(1'b0, 16'h0000, 1'b0, "R8", acc);   // RELEASE -> aux item at head
        step(1'b0, 16'h0000, 1'b1, "R7", acc);   // HALF retry hold
        step(1'b0, 16'h0000, 1'b0, "R6", acc);   // DRAIN -> EMPTY
        step(1'b0, 16'h1111, 1'b0, "R3", acc);   // idle stays empty
        step(1'b1, 16'h0F06, 1'b1, "R3", acc);   // FILL while receiver stopped
        step(1'b1, 16'h0F07, 1'b1, "R5", acc);   // STALL
        step(1'b1, 16'h0F08, 1'b0, "R8", acc);   // RELEASE, input not taken
        step(1'b1, 16'h0F08, 1'b0, "R4", acc);   // PASS takes the held item
        step(1'b0, 16'h0000, 1'b0, "R6", acc);   // DRAIN

        // Random traffic with a persistent sender
        pending = 1'b0;
        item    = 16'h2000;
        for (int ph = 0; ph < 4; ph++) begin
            for (int c = 0; c < 500; c++) begin
                if (!pending && ($urandom_range(99) < vprob[ph])) begin
                    pending = 1'b1;
                    item    = item + 16'd1;
                end
                step(pending, pending ? item : 16'hDEAD,
                     ($urandom_range(99) < sprob[ph]), "R10", acc);
                if (acc) pending = 1'b0;
            end
        end
        for (int k = 0; k < 4; k++) step(1'b0, 16'h0000, 1'b0, "R10", acc);
        chk("R10", "queue_empty", W'(ref_q.size()), '0);
        chk("R10", "final_valid", W'(out_v), '0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule